// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns a 32-bit instruction word into the steering and enable signals a single-issue datapath needs, plus the 4-bit operation code for the arithmetic unit. It works in two levels. The first level looks only at the major opcode field and sets the register-file, memory, branch and jump controls, together with a 2-bit operation class. The second level uses that class and the function field to choose the arithmetic unit's operation.

The supported instructions are register-to-register arithmetic and logic, word load, word store, branch-on-equal and unconditional jump. All outputs are registered. An instruction presented on a clock edge shows its controls one cycle later, which lets the decode slot into a pipeline register stage. An unrecognised opcode produces a control word that can change no architectural state.

Top module: `ctrl_decoder`

## Requirements
- R1: Outputs are registered with a latency of one cycle. A synchronous active-high reset forces every output to 0.
- R2: Opcode 0x00 (bits 31:26) sets dst_rd=1, reg_we=1, operation class 10, and all of src_imm, wb_mem, mem_re, mem_we, branch and jump to 0.
- R3: Opcode 0x23 sets src_imm=1, wb_mem=1, reg_we=1, mem_re=1, operation class 00, and dst_rd, mem_we, branch and jump to 0.
- R4: Opcode 0x2B sets src_imm=1, mem_we=1, operation class 00, and dst_rd, wb_mem, reg_we, mem_re, branch and jump to 0.
- R5: Opcode 0x04 sets branch=1, operation class 01, and every other enable and select to 0.
- R6: Opcode 0x02 sets jump=1, operation class 00, and every other enable and select to 0.
- R7: Operation class 00 gives ALU code 0010 (add). Operation class 01 gives ALU code 0110 (subtract). In both cases the function field is ignored.
- R8: When the high bit of the operation class is set, the function field (bits 5:0) selects the ALU code as follows: 0x24 gives 0000 (and), 0x25 gives 0001 (or), 0x20 gives 0010 (add), 0x22 gives 0110 (subtract), 0x2A gives 0111 (set-less-than), and 0x27 gives 1100 (nor).
- R9: A register-format instruction with any other function code gives ALU code 0000, and its other controls stay as in R2.
- R10: Any other opcode drives every output bit to 0, except the ALU code, which is 0010.
- R11: Bits 25:6 of the instruction have no effect on any output.
- R12: mem_re and mem_we are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| dst_rd_o | output | 1 | Destination register taken from the rd field |
| src_imm_o | output | 1 | Second ALU operand is the sign-extended immediate |
| wb_mem_o | output | 1 | Write-back data comes from memory |
| reg_we_o | output | 1 | Register file write enable |
| mem_re_o | output | 1 | Data memory read enable |
| mem_we_o | output | 1 | Data memory write enable |
| branch_o | output | 1 | Conditional branch on equal |
| jump_o | output | 1 | Unconditional jump |
| alu_op_o | output | 2 | Operation class |
| alu_ctl_o | output | 4 | ALU operation code |

## Verification
The bench drives every opcode and every function code in turn. It sets the middle 20 bits to random-looking values on each instruction. A decoder that reads any register-number or immediate bit would then show that bit through a control output, which breaks R11. Memory instructions are sent with function-field bits that match subtract and nor. A second level that consults the function field when it should force add would therefore give the wrong ALU code. The bench also sends unknown opcodes and an unknown function code right after valid instructions, to catch an output register that keeps a stale enable. Reset is applied again in the middle of the run to check that the registered outputs clear at once.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int AC_W  = 4;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_JMP   = 6'h02;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_NOR = 6'h27;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    CLS_ADD  = 2'b00,
    CLS_SUB  = 2'b01,
    CLS_FUNC = 2'b10
  } op_class_e;

  typedef enum logic [AC_W-1:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_code_e;

  typedef struct packed {
    logic      dst_rd;
    logic      src_imm;
    logic      wb_mem;
    logic      reg_we;
    logic      mem_re;
    logic      mem_we;
    logic      branch;
    logic      jump;
    logic [1:0] op_class;
  } ctrl_t;
endpackage

// File: rtl/ctrl_main_dec.sv
module ctrl_main_dec
  import ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output ctrl_t            ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    ctrl_o.op_class = CLS_ADD;
    unique case (opc_i)
      OPC_REG: begin
        ctrl_o.dst_rd   = 1'b1;
        ctrl_o.reg_we   = 1'b1;
        ctrl_o.op_class = CLS_FUNC;
      end
      OPC_LOAD: begin
        ctrl_o.src_imm = 1'b1;
        ctrl_o.wb_mem  = 1'b1;
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.mem_re  = 1'b1;
      end
      OPC_STORE: begin
        ctrl_o.src_imm = 1'b1;
        ctrl_o.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl_o.branch   = 1'b1;
        ctrl_o.op_class = CLS_SUB;
      end
      OPC_JMP: begin
        ctrl_o.jump = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ctrl_alu_dec.sv
module ctrl_alu_dec
  import ctrl_pkg::*;
(
  input  logic [1:0]      op_class_i,
  input  logic [FN_W-1:0] fn_i,
  output logic [AC_W-1:0] alu_ctl_o
);
  logic [AC_W-1:0] fn_code;

  always_comb begin
    unique case (fn_i)
      FN_ADD:  fn_code = ALU_ADD;
      FN_SUB:  fn_code = ALU_SUB;
      FN_AND:  fn_code = ALU_AND;
      FN_OR:   fn_code = ALU_OR;
      FN_NOR:  fn_code = ALU_NOR;
      FN_SLT:  fn_code = ALU_SLT;
      default: fn_code = ALU_AND;
    endcase
  end

  always_comb begin
    if (op_class_i[1])      alu_ctl_o = fn_code;
    else if (op_class_i[0]) alu_ctl_o = ALU_SUB;
    else                    alu_ctl_o = ALU_ADD;
  end
endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
  import ctrl_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               dst_rd_o,
  output logic               src_imm_o,
  output logic               wb_mem_o,
  output logic               reg_we_o,
  output logic               mem_re_o,
  output logic               mem_we_o,
  output logic               branch_o,
  output logic               jump_o,
  output logic [1:0]         alu_op_o,
  output logic [AC_W-1:0]    alu_ctl_o
);
  localparam int OPC_LSB = INSTR_W - OPC_W;

  logic [OPC_W-1:0] opc;
  logic [FN_W-1:0]  fn;
  logic             unused_mid;
  ctrl_t            ctrl_d;
  logic [AC_W-1:0]  alu_d;

  assign opc        = instr_i[INSTR_W-1:OPC_LSB];
  assign fn         = instr_i[FN_W-1:0];
  assign unused_mid = ^instr_i[OPC_LSB-1:FN_W];

  ctrl_main_dec u_main (
    .opc_i  (opc),
    .ctrl_o (ctrl_d)
  );

  ctrl_alu_dec u_alu (
    .op_class_i (ctrl_d.op_class),
    .fn_i       (fn),
    .alu_ctl_o  (alu_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      {dst_rd_o, src_imm_o, wb_mem_o, reg_we_o, mem_re_o,
       mem_we_o, branch_o, jump_o, alu_op_o} <= '0;
      alu_ctl_o <= '0;
    end else begin
      {dst_rd_o, src_imm_o, wb_mem_o, reg_we_o, mem_re_o,
       mem_we_o, branch_o, jump_o, alu_op_o} <= ctrl_d;
      alu_ctl_o <= alu_d;
    end
  end
endmodule

// File: rtl/ctrl_decoder_chk.sv
module ctrl_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] opc,
  input logic [5:0] fn,
  input logic       dst_rd,
  input logic       src_imm,
  input logic       wb_mem,
  input logic       reg_we,
  input logic       mem_re,
  input logic       mem_we,
  input logic       branch,
  input logic       jump,
  input logic [1:0] alu_op,
  input logic [3:0] alu_ctl
);
  // R1: a cycle in reset leaves all outputs at zero
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> ({dst_rd, src_imm, wb_mem, reg_we, mem_re, mem_we,
                     branch, jump, alu_op, alu_ctl} == '0));

  // R2
  a_r2_reg_format: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opc) == 6'h00) |->
      (dst_rd && reg_we && alu_op == 2'b10 && !mem_re && !mem_we && !branch && !jump));

  // R3
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opc) == 6'h23) |->
      (wb_mem && mem_re && reg_we && src_imm && alu_ctl == 4'b0010));

  // R5
  a_r5_branch: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opc) == 6'h04) |->
      (branch && !reg_we && !mem_we && alu_ctl == 4'b0110));

  // R8: subtract function code under register format
  a_r8_fn_sub: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opc) == 6'h00 && $past(fn) == 6'h22) |-> (alu_ctl == 4'b0110));

  // R10
  a_r10_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(opc) inside {6'h00, 6'h23, 6'h2B, 6'h04, 6'h02})) |->
      (!reg_we && !mem_we && !mem_re && !branch && !jump));

  // R12
  a_r12_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({mem_re, mem_we}) <= 1);
endmodule

bind ctrl_decoder ctrl_decoder_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .opc     (instr_i[INSTR_W-1 -: 6]),
  .fn      (instr_i[5:0]),
  .dst_rd  (dst_rd_o),
  .src_imm (src_imm_o),
  .wb_mem  (wb_mem_o),
  .reg_we  (reg_we_o),
  .mem_re  (mem_re_o),
  .mem_we  (mem_we_o),
  .branch  (branch_o),
  .jump    (jump_o),
  .alu_op  (alu_op_o),
  .alu_ctl (alu_ctl_o)
);

// File: tb/tb_ctrl_decoder.sv
module tb_ctrl_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic dst_rd, src_imm, wb_mem, reg_we, mem_re, mem_we, branch, jump;
  logic [1:0] alu_op;
  logic [3:0] alu_ctl;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  typedef struct {
    logic [13:0] exp;
    string       tag;
    logic [31:0] word;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  ctrl_decoder dut (
    .clk(clk), .rst(rst), .instr_i(instr),
    .dst_rd_o(dst_rd), .src_imm_o(src_imm), .wb_mem_o(wb_mem),
    .reg_we_o(reg_we), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .branch_o(branch), .jump_o(jump), .alu_op_o(alu_op), .alu_ctl_o(alu_ctl)
  );

  function automatic logic [13:0] model(input logic [31:0] w);
    logic [9:0] c;
    logic [3:0] a;
    case (w[31:26])
      6'h00:   c = 10'b1001000010;  // R2
      6'h23:   c = 10'b0111100000;  // R3
      6'h2B:   c = 10'b0100010000;  // R4
      6'h04:   c = 10'b0000001001;  // R5
      6'h02:   c = 10'b0000000100;  // R6
      default: c = 10'b0000000000;  // R10
    endcase
    if (c[1]) begin
      case (w[5:0])
        6'h24: a = 4'b0000;
        6'h25: a = 4'b0001;
        6'h20: a = 4'b0010;
        6'h22: a = 4'b0110;
        6'h2A: a = 4'b0111;
        6'h27: a = 4'b1100;
        default: a = 4'b0000;  // R9
      endcase
    end else if (c[0]) a = 4'b0110;  // R7
    else a = 4'b0010;               // R7
    return {c, a};
  endfunction

  function automatic logic [13:0] observed();
    return {dst_rd, src_imm, wb_mem, reg_we, mem_re, mem_we, branch, jump, alu_op, alu_ctl};
  endfunction

  task automatic drive(input logic [31:0] w, input string tag);
    item_t it;
    it.exp = model(w);
    it.tag = tag;
    it.word = w;
    instr = w;
    sb.push_back(it);
    @(negedge clk);
  endtask

  // monitor: 2 ns after each edge the register holds the decode of the word driven before it
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (observed() !== it.exp) begin
        fails++;
        $display("FAIL %s instr=%h actual=%b expected=%b", it.tag, it.word, observed(), it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check_reset(input string tag);
    @(posedge clk);
    #2;
    checks++;
    if (observed() !== 14'd0) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, observed(), 14'd0);
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [19:0] mid,
                                     input logic [5:0] fn);
    return {op, mid, fn};
  endfunction

  initial begin
    logic [19:0] mid;
    mid = 20'h5A3C1;
    instr = 32'hFFFF_FFFF;
    @(negedge clk);
    check_reset("R1 reset");
    rst = 1'b0;
    @(negedge clk);
    // R8 every function code, R2 register-format controls
    drive(mk(6'h00, 20'h0, 6'h20), "R8 add");
    drive(mk(6'h00, 20'hFFFFF, 6'h22), "R8 sub");
    drive(mk(6'h00, mid, 6'h24), "R8 and");
    drive(mk(6'h00, mid, 6'h25), "R8 or");
    drive(mk(6'h00, mid, 6'h27), "R8 nor");
    drive(mk(6'h00, mid, 6'h2A), "R8 slt");
    drive(mk(6'h00, mid, 6'h21), "R9 unknown fn");
    drive(mk(6'h00, mid, 6'h3F), "R9 unknown fn");
    drive(mk(6'h00, 20'h0, 6'h20), "R2 reg format");
    // R3, R4 with function bits that decode as non-add (R7)
    drive(mk(6'h23, mid, 6'h22), "R3 load / R7 force add");
    drive(mk(6'h2B, mid, 6'h27), "R4 store / R7 force add");
    drive(mk(6'h23, 20'h0, 6'h00), "R3 load");
    // R5 branch with add function bits: must still subtract
    drive(mk(6'h04, mid, 6'h20), "R5 branch / R7 force sub");
    drive(mk(6'h02, mid, 6'h2A), "R6 jump");
    // R10 unknown opcodes directly after writers
    drive(mk(6'h00, mid, 6'h20), "R2 reg format");
    drive(mk(6'h3F, mid, 6'h20), "R10 unknown op");
    drive(mk(6'h2B, mid, 6'h00), "R4 store");
    drive(mk(6'h08, mid, 6'h2A), "R10 unknown op");
    // R11 sweep middle bits, R12 exclusivity implied by expected word
    for (int i = 0; i < 40; i++) begin
      logic [19:0] m;
      m = 20'(i * 32'h9E37 + 32'h1234);
      drive(mk(6'h23, m, 6'(i)), "R11 mid bits load");
      drive(mk(6'h2B, m, 6'(i)), "R12 store exclusive");
      drive(mk(6'h00, m, 6'h2A), "R11 mid bits slt");
    end
    // R10 every opcode
    for (int op = 0; op < 64; op++) begin
      drive(mk(6'(op), mid ^ 20'(op), 6'(op + 32)), "R10 opcode sweep");
    end
    @(negedge clk);
    rst = 1'b1;
    instr = mk(6'h23, mid, 6'h20);
    check_reset("R1 mid-run reset");
    rst = 1'b0;
    drive(mk(6'h04, 20'h0, 6'h00), "R5 after reset");
    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule